// File: doc/BRIEF.md
# Masked Local-Bus Interrupt Controller

This block gathers sixteen level-sensitive request lines from local peripherals and qualifies them with a software-programmed enable mask. When any enabled line is high, it raises a single interrupt toward the processor. The source state is the live input level. Nothing is latched, so a line that drops is no longer pending.

Software does not read a raw bitmap of the sources. It reads an encoded vector: four times one plus the index of the lowest-numbered pending line, or zero when no line is pending. The handler can use this value directly as a table offset. The mask register can be read and written.

The register window is four bytes wide:

- Offset 0 is the vector, which is read-only.
- Offset 2 is the mask.

Accesses may be byte, halfword or word wide. A byte write is merged into the current halfword. A word access covers the vector as its low half and the mask as its high half.

Top module: `irq_mask_ctl`

## Requirements
- R1: The source state is the present level of `irq_lines`. A line that returns low stops counting as pending, with no acknowledge needed.
- R2: `irq_out` is registered. After each rising edge it equals the OR of (`irq_lines` AND mask) as sampled at that edge, and a mask write at that same edge is already included.
- R3: A vector read returns (n+1)*4 for the lowest-numbered line n that is both high and enabled, or 0 when no line is. Line 0 has the highest priority and line 15 gives 64.
- R4: After reset the mask is 0x0010, so only line 4 is enabled. After reset `irq_out` and `bus_rvalid` are 0.
- R5: A halfword write (`bus_size`=01) with `bus_addr[1]`=1 replaces the whole mask with `bus_wdata[15:0]`. A halfword read at that offset returns the mask.
- R6: A byte write (`bus_size`=00) takes `bus_wdata[7:0]`. At offset 2 it replaces mask bits 7:0, and at offset 3 it replaces mask bits 15:8. The other byte is kept.
- R7: A word access (`bus_size`=10 or 11) acts as a halfword access at offset 0 followed by one at offset 2. A word write loads the mask from `bus_wdata[31:16]`, and a word read returns {mask, vector}.
- R8: Writes at offsets 0 and 1 (the vector) have no effect on any state.
- R9: Read data and `bus_rvalid` appear one cycle after the request. A byte read returns the addressed byte of {mask, vector} zero-extended, and a halfword read returns its half zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 16 | Level-sensitive request lines, bit n is line n |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Byte offset in the register window |
| bus_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| bus_wdata | input | 32 | Write data, right-aligned for byte and halfword |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Marks valid `bus_rdata` |
| irq_out | output | 1 | Combined registered interrupt |

## Verification
The hardest case to reach is a mask write landing on the same edge at which the interrupt output is computed. The output must already follow the new mask, not the old one. The stimulus parks a request on a disabled line, confirms the output is low, then writes a mask that enables only that line and samples the output right after that single edge.

Priority ordering is covered by holding several lines high at once, with a masked lower line present, and by placing line 15 alone to reach the largest vector value.

// File: rtl/irq_mask_ctl.sv
module irq_mask_ctl #(
  parameter int N_LINES = 16,
  parameter logic [15:0] MASK_RESET = 16'h0010
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] irq_lines,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [1:0]  bus_size,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_rvalid,
  output logic        irq_out
);
  localparam int VEC_W = 16;

  logic [15:0] mask_q, mask_d;
  logic [15:0] pending;
  logic [VEC_W-1:0] vec;
  logic [31:0] window;
  logic [31:0] rdata_d;
  logic        irq_q;

  assign pending = irq_lines & mask_q & 16'((32'h1 << N_LINES) - 1);

  always_comb begin
    vec = '0;
    for (int i = N_LINES - 1; i >= 0; i--)
      if (pending[i]) vec = VEC_W'((i + 1) * 4);
  end

  assign window = {mask_q, vec};

  always_comb begin
    mask_d = mask_q;
    if (bus_sel && bus_we) begin
      case (bus_size)
        2'b00: begin
          if (bus_addr == 2'd2) mask_d[7:0]  = bus_wdata[7:0];
          if (bus_addr == 2'd3) mask_d[15:8] = bus_wdata[7:0];
        end
        2'b01: if (bus_addr[1]) mask_d = bus_wdata[15:0];
        default: mask_d = bus_wdata[31:16];
      endcase
    end
  end

  always_comb begin
    case (bus_size)
      2'b00:   rdata_d = {24'h0, window[8*bus_addr +: 8]};
      2'b01:   rdata_d = {16'h0, bus_addr[1] ? window[31:16] : window[15:0]};
      default: rdata_d = window;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q     <= MASK_RESET;
      irq_q      <= 1'b0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      mask_q     <= mask_d;
      irq_q      <= |(irq_lines & mask_d);
      bus_rvalid <= bus_sel && !bus_we;
      if (bus_sel && !bus_we) bus_rdata <= rdata_d;
    end
  end

  assign irq_out = irq_q;
endmodule

// File: rtl/irq_mask_ctl_sva.sv
module irq_mask_ctl_sva (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] irq_lines,
  input logic [15:0] mask_q,
  input logic        bus_sel,
  input logic        bus_we,
  input logic [1:0]  bus_addr,
  input logic [1:0]  bus_size,
  input logic [31:0] bus_rdata,
  input logic        irq_out
);
  logic started;
  always_ff @(posedge clk) begin
    started <= rst_n;
    if (rst_n && !started)
      assert_mask_reset_R4: assert (mask_q == 16'h0010);
  end

  assert_irq_follows_R2: assert property (@(posedge clk) disable iff (!started)
    irq_out == |($past(irq_lines) & mask_q));

  assert_vector_form_R3: assert property (@(posedge clk) disable iff (!started)
    $past(bus_sel && !bus_we && bus_size == 2'b01 && !bus_addr[1]) |->
      (bus_rdata[1:0] == 2'b00 && bus_rdata[31:16] == 16'h0 && bus_rdata[15:0] <= 16'd64 &&
       ((bus_rdata[15:0] == 16'h0) == (($past(irq_lines) & $past(mask_q)) == 16'h0))));

  assert_mask_holds_R5: assert property (@(posedge clk) disable iff (!started)
    !$past(bus_sel && bus_we) |-> $stable(mask_q));

  assert_vector_write_ignored_R8: assert property (@(posedge clk) disable iff (!started)
    $past(bus_sel && bus_we && bus_size != 2'b10 && bus_size != 2'b11 && !bus_addr[1]) |-> $stable(mask_q));
endmodule

bind irq_mask_ctl irq_mask_ctl_sva u_sva (
  .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .mask_q(mask_q),
  .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
  .bus_rdata(bus_rdata), .irq_out(irq_out)
);

// File: tb/test_irq_mask_ctl.sv
module test_irq_mask_ctl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] irq_lines = '0;
  logic        bus_sel = 0, bus_we = 0;
  logic [1:0]  bus_addr = '0, bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, irq_out;

  int applied = 0, bad = 0;
  logic [15:0] m_mask = 16'h0010;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  irq_mask_ctl i_irq_mask_ctl (.*);

  function automatic logic [15:0] exp_vec(logic [15:0] p);
    for (int i = 15; i >= 0; i--) if (p[i]) exp_vec = 16'((i + 1) * 4);
    if (p == 0) exp_vec = 0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (bus_rvalid) begin
    if (exp_q.size() == 0) check("R9 unexpected rvalid", 1, 0);
    else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
  end

  task automatic wr(logic [1:0] a, logic [1:0] sz, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_size = sz; bus_wdata = d;
    case (sz)
      2'b00: begin if (a == 2) m_mask[7:0] = d[7:0]; if (a == 3) m_mask[15:8] = d[7:0]; end
      2'b01: if (a[1]) m_mask = d[15:0];
      default: m_mask = d[31:16];
    endcase
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [1:0] a, logic [1:0] sz, string tag);
    logic [31:0] win;
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a; bus_size = sz;
    win = {m_mask, exp_vec(irq_lines & m_mask)};
    case (sz)
      2'b00: exp_q.push_back({24'h0, win[8*a +: 8]});
      2'b01: exp_q.push_back({16'h0, a[1] ? win[31:16] : win[15:0]});
      default: exp_q.push_back(win);
    endcase
    tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic lines(logic [15:0] v);
    @(negedge clk); irq_lines = v;
    @(negedge clk); check("R2 irq_out", irq_out, |(v & m_mask));
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    check("watchdog expired", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R4 irq_out after reset", irq_out, 0);
    check("R4 rvalid after reset", bus_rvalid, 0);
    rd(2'd2, 2'b01, "R4 mask reset value");
    lines(16'h0010);
    rd(2'd0, 2'b01, "R3 vector line 4");
    lines(16'h0011);
    rd(2'd0, 2'b01, "R3 masked line 0 skipped");
    wr(2'd2, 2'b01, 32'h0000_FFFF);
    rd(2'd2, 2'b01, "R5 mask readback");
    rd(2'd0, 2'b01, "R3 lowest line wins");
    lines(16'h8000);
    rd(2'd0, 2'b01, "R3 line 15 gives 64");
    lines(16'h0000);
    rd(2'd0, 2'b01, "R1 dropped line no longer pending");
    wr(2'd2, 2'b00, 32'h0000_0000);
    rd(2'd2, 2'b01, "R6 byte write low lane");
    wr(2'd3, 2'b00, 32'h0000_0012);
    rd(2'd2, 2'b01, "R6 byte write high lane");
    rd(2'd3, 2'b00, "R9 byte read offset 3");
    rd(2'd2, 2'b00, "R9 byte read offset 2");
    wr(2'd0, 2'b01, 32'h0000_ABCD);
    wr(2'd0, 2'b00, 32'h0000_00EE);
    wr(2'd1, 2'b00, 32'h0000_00EE);
    rd(2'd2, 2'b01, "R8 vector writes ignored");
    wr(2'd0, 2'b10, 32'h5A5A_1234);
    lines(16'h0002);
    rd(2'd0, 2'b10, "R7 word read mask and vector");
    rd(2'd2, 2'b01, "R7 word write loads mask");
    lines(16'h0001);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = 2'd2; bus_size = 2'b01; bus_wdata = 32'h0000_0001;
    m_mask = 16'h0001;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
    check("R2 mask write same edge", irq_out, 1);
    lines(16'h0000);
    check("R1 irq drops with line", irq_out, 0);
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check("R9 missing read data", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule